// File: doc/BRIEF.md
# Ethernet Test Frame Generator

A synthesizable traffic source that writes a run of Ethernet frames onto an 8-bit byte stream qualified by a valid strobe, in the shape a MAC receive path expects from its line side. A one-cycle start pulse takes a snapshot of the configuration and launches the run. The configuration gives the number of frames, the payload length of the first frame, a length step, a length ceiling, the idle gap between frames, a padding switch and a VLAN switch. The block builds every byte itself: the preamble, the start delimiter, both addresses, the optional VLAN tag, the length field, the payload, the zero padding and the CRC-32 frame check sequence.

The payload length walks upward by the step from frame to frame. When the next value would exceed the ceiling, it wraps to zero, so a single run can cover long, short and empty payloads. With padding switched off, short frames leave the block undersized, which exercises the runt handling of a receiver. A pause input, gated by its own enable, holds traffic at the next frame boundary to imitate a flow-control stop. Traffic resumes when the pause is released.

Top module: `eth_tgen`

## Requirements
- R1: While reset is asserted and after it is released, tx_valid and busy are 0 until a start pulse is accepted.
- R2: A start pulse seen while busy is 0 and cfg_count is N>0 makes busy rise on the next cycle. The block then emits exactly N frames, and busy falls together with tx_valid after the last FCS byte. A start with cfg_count = 0 emits nothing, and a start while busy is 1 is ignored.
- R3: Every frame is seven 0x55 bytes, one 0xD5 byte, the destination address 02:11:22:33:44:55, the source address 02:66:77:88:99:AA and a 16-bit type/length field (most significant byte first) equal to the unpadded payload length. The payload bytes follow as 0x00, 0x01, 0x02, and so on, restarting at 0 in each frame.
- R4: The first frame of a run carries cfg_len_first payload bytes. Each later frame carries the previous length plus cfg_len_step, or 0 when that sum is greater than cfg_len_max.
- R5: With cfg_pad_en = 1, zero bytes follow the payload until the bytes from the destination address through the padding number 60, so the frame is 64 octets with the FCS. A frame that is already that long gets no padding.
- R6: With cfg_pad_en = 0, no padding is added, and a short frame goes out with fewer than 64 octets from the destination address through the FCS.
- R7: With cfg_vlan_en = 1, the four bytes 0x81, 0x00, 0x20, 0x64 sit between the source address and the type/length field of every frame.
- R8: Four FCS bytes end each frame. They are the complement of a reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) taken over the destination address through the padding, sent least significant byte first.
- R9: tx_valid stays high for the whole of a frame. Between two frames of a run it is low for max(cfg_gap, 1) cycles.
- R10: While pause_en and pause are both 1, no new frame starts. A frame already in progress completes, and the run continues once pause falls. With pause_en = 0, pause has no effect.
- R11: Changes to the configuration inputs during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a run |
| cfg_count | input | CNT_W | Number of frames in the run |
| cfg_len_first | input | LEN_W | Payload length of the first frame |
| cfg_len_step | input | LEN_W | Payload length increment per frame |
| cfg_len_max | input | LEN_W | Payload length ceiling before the wrap to zero |
| cfg_gap | input | GAP_W | Idle byte times between frames |
| cfg_pad_en | input | 1 | Pad short frames to 64 octets |
| cfg_vlan_en | input | 1 | Insert a VLAN tag in every frame |
| pause_en | input | 1 | Let pause hold traffic |
| pause | input | 1 | Flow-control hold request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | tx_data carries a frame byte |
| busy | output | 1 | A run is in progress |

## Verification
The bench checks each frame against a model built from the requirements. It targets the length wrap, both when the sum lands just past the ceiling and when the first length already equals it. A design that wrapped on equality or kept the overflowed value would put the wrong number in the type field. Padding runs with payloads of 0, 10 and 47 bytes, with and without the VLAN tag, to find a pad count that ignores the tag or overshoots 60 bytes. A gap of zero must still give one idle cycle. The bench raises pause in the middle of a frame, which catches a design that cuts the frame short or starts the next one anyway. A start given during a run carries a different configuration, which catches a design that restarts or takes the new settings.

// File: rtl/eth_tgen_pkg.sv
package eth_tgen_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_PRE,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_FCS
   } tg_state_t;

   localparam int          MIN_BODY   = 60;
   localparam int          PRE_LAST   = 7;
   localparam int          FCS_LAST   = 3;
   localparam logic [7:0]  PRE_BYTE   = 8'h55;
   localparam logic [7:0]  SFD_BYTE   = 8'hD5;
   localparam logic [15:0] VLAN_TPID  = 16'h8100;
   localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

endpackage

// File: rtl/eth_tgen_lenseq.sv
module eth_tgen_lenseq #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [LEN_W-1:0] first,
   input  logic [LEN_W-1:0] step,
   input  logic [LEN_W-1:0] lmax,
   output logic [LEN_W-1:0] len
);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] step_q;
   logic [LEN_W-1:0] max_q;
   logic [LEN_W:0]   sum;

   assign sum = {1'b0, len_q} + {1'b0, step_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= '0;
         step_q <= '0;
         max_q  <= '0;
      end else if (load) begin
         len_q  <= first;
         step_q <= step;
         max_q  <= lmax;
      end else if (adv) begin
         if (sum > {1'b0, max_q})
            len_q <= '0;
         else
            len_q <= sum[LEN_W-1:0];
      end
   end

   assign len = len_q;

endmodule

// File: rtl/eth_tgen_crc.sv
module eth_tgen_crc
   import eth_tgen_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc
);

   logic [31:0] crc_q;
   logic [31:0] stage [0:8];

   assign stage[0] = crc_q;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      assign stage[b+1] = (stage[b][0] ^ din[b]) ? ((stage[b] >> 1) ^ CRC_POLY)
                                                 : (stage[b] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc_q <= '1;
      else if (init)
         crc_q <= '1;
      else if (en)
         crc_q <= stage[8];
   end

   assign crc = crc_q;

endmodule

// File: rtl/eth_tgen_fsm.sv
module eth_tgen_fsm
   import eth_tgen_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LEN_W = 11,
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cfg_pad_en,
   input  logic             cfg_vlan_en,
   input  logic             pause_en,
   input  logic             pause,
   input  logic [LEN_W-1:0] cur_len,
   output tg_state_t        state_o,
   output logic [LEN_W-1:0] idx_o,
   output logic             vlan_o,
   output logic             busy_o,
   output logic             len_load_o,
   output logic             len_adv_o,
   output logic             crc_init_o
);

   localparam int               BODY_W   = 7;
   localparam logic [BODY_W-1:0] BODY_MIN = BODY_W'(MIN_BODY);
   localparam logic [LEN_W-1:0]  IDX_PRE  = LEN_W'(PRE_LAST);
   localparam logic [LEN_W-1:0]  IDX_FCS  = LEN_W'(FCS_LAST);
   localparam logic [LEN_W-1:0]  HDR_PLAIN = LEN_W'(13);
   localparam logic [LEN_W-1:0]  HDR_TAGGED = LEN_W'(17);

   tg_state_t         state_q;
   logic [LEN_W-1:0]  idx_q;
   logic [CNT_W-1:0]  rem_q;
   logic [GAP_W-1:0]  gap_q;
   logic [GAP_W-1:0]  gcnt_q;
   logic              pad_q;
   logic              vlan_q;
   logic [BODY_W-1:0] body_q;

   logic [BODY_W-1:0] body_sat;
   logic              pad_more;
   logic [GAP_W:0]    gnext;
   logic              gap_hit;
   logic              halt;
   logic [LEN_W-1:0]  hdr_last;
   logic [LEN_W-1:0]  idx_inc;
   logic              launch;

   assign body_sat = (body_q == '1) ? body_q : body_q + 1'b1;
   assign pad_more = pad_q && (body_sat < BODY_MIN);
   assign gnext    = {1'b0, gcnt_q} + {{GAP_W{1'b0}}, 1'b1};
   assign gap_hit  = gnext >= {1'b0, gap_q};
   assign halt     = pause_en && pause;
   assign hdr_last = vlan_q ? HDR_TAGGED : HDR_PLAIN;
   assign idx_inc  = idx_q + 1'b1;
   assign launch   = (state_q == ST_IDLE) && start && (cfg_count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         rem_q   <= '0;
         gap_q   <= '0;
         gcnt_q  <= '0;
         pad_q   <= 1'b0;
         vlan_q  <= 1'b0;
         body_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (launch) begin
                  rem_q   <= cfg_count;
                  gap_q   <= cfg_gap;
                  gcnt_q  <= cfg_gap;
                  pad_q   <= cfg_pad_en;
                  vlan_q  <= cfg_vlan_en;
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_hit && !halt) begin
                  state_q <= ST_PRE;
                  idx_q   <= '0;
               end else if (!gap_hit) begin
                  gcnt_q  <= gnext[GAP_W-1:0];
               end
            end
            ST_PRE: begin
               body_q <= '0;
               if (idx_q == IDX_PRE) begin
                  state_q <= ST_HDR;
                  idx_q   <= '0;
               end else begin
                  idx_q   <= idx_inc;
               end
            end
            ST_HDR: begin
               body_q <= body_sat;
               if (idx_q == hdr_last) begin
                  idx_q <= '0;
                  if (cur_len != '0)
                     state_q <= ST_PAY;
                  else if (pad_more)
                     state_q <= ST_PAD;
                  else
                     state_q <= ST_FCS;
               end else begin
                  idx_q <= idx_inc;
               end
            end
            ST_PAY: begin
               body_q <= body_sat;
               if (idx_q == cur_len - 1'b1) begin
                  idx_q   <= '0;
                  state_q <= pad_more ? ST_PAD : ST_FCS;
               end else begin
                  idx_q   <= idx_inc;
               end
            end
            ST_PAD: begin
               body_q <= body_sat;
               if (!pad_more) begin
                  idx_q   <= '0;
                  state_q <= ST_FCS;
               end
            end
            ST_FCS: begin
               if (idx_q == IDX_FCS) begin
                  idx_q <= '0;
                  if (rem_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                     state_q <= ST_IDLE;
                  end else begin
                     rem_q   <= rem_q - 1'b1;
                     gcnt_q  <= '0;
                     state_q <= ST_GAP;
                  end
               end else begin
                  idx_q <= idx_inc;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o    = state_q;
   assign idx_o      = idx_q;
   assign vlan_o     = vlan_q;
   assign busy_o     = state_q != ST_IDLE;
   assign len_load_o = launch;
   assign len_adv_o  = (state_q == ST_FCS) && (idx_q == IDX_FCS);
   assign crc_init_o = state_q == ST_PRE;

endmodule

// File: rtl/eth_tgen_bytemux.sv
module eth_tgen_bytemux
   import eth_tgen_pkg::*;
#(
   parameter int          LEN_W    = 11,
   parameter logic [47:0] DST_ADDR = 48'h02_11_22_33_44_55,
   parameter logic [47:0] SRC_ADDR = 48'h02_66_77_88_99_AA,
   parameter logic [15:0] TAG_CTRL = 16'h2064
) (
   input  tg_state_t        state,
   input  logic [LEN_W-1:0] idx,
   input  logic [LEN_W-1:0] len,
   input  logic             vlan,
   input  logic [31:0]      crc,
   output logic [7:0]       data,
   output logic             valid,
   output logic             crc_en
);

   localparam int HDR_BYTES = 18;

   logic [15:0]            type_fld;
   logic [HDR_BYTES*8-1:0] hdr_vec;
   logic [4:0]             hsel;
   logic [31:0]            fcs;

   assign type_fld = 16'(len);
   assign hdr_vec  = vlan ? {DST_ADDR, SRC_ADDR, VLAN_TPID, TAG_CTRL, type_fld}
                          : {DST_ADDR, SRC_ADDR, type_fld, 32'h0};
   assign hsel     = idx[4:0];
   assign fcs      = ~crc;

   always_comb begin
      data  = 8'h00;
      valid = 1'b1;
      case (state)
         ST_PRE: data = (idx == LEN_W'(PRE_LAST)) ? SFD_BYTE : PRE_BYTE;
         ST_HDR: data = hdr_vec[(HDR_BYTES - 1 - int'(hsel)) * 8 +: 8];
         ST_PAY: data = idx[7:0];
         ST_PAD: data = 8'h00;
         ST_FCS: data = fcs[int'(idx[1:0]) * 8 +: 8];
         default: valid = 1'b0;
      endcase
   end

   assign crc_en = (state == ST_HDR) || (state == ST_PAY) || (state == ST_PAD);

endmodule

// File: rtl/eth_tgen.sv
module eth_tgen
   import eth_tgen_pkg::*;
#(
   parameter int          CNT_W    = 16,
   parameter int          LEN_W    = 11,
   parameter int          GAP_W    = 8,
   parameter logic [47:0] DST_ADDR = 48'h02_11_22_33_44_55,
   parameter logic [47:0] SRC_ADDR = 48'h02_66_77_88_99_AA,
   parameter logic [15:0] TAG_CTRL = 16'h2064
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic [LEN_W-1:0] cfg_len_first,
   input  logic [LEN_W-1:0] cfg_len_step,
   input  logic [LEN_W-1:0] cfg_len_max,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cfg_pad_en,
   input  logic             cfg_vlan_en,
   input  logic             pause_en,
   input  logic             pause,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   output logic             busy
);

   if (LEN_W < 6 || LEN_W > 16) begin : g_bad_len
      $error("eth_tgen: LEN_W must lie in 6..16");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("eth_tgen: CNT_W must lie in 1..32");
   end
   if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
      $error("eth_tgen: GAP_W must lie in 1..16");
   end

   tg_state_t        state;
   logic [LEN_W-1:0] idx;
   logic [LEN_W-1:0] cur_len;
   logic             vlan;
   logic             len_load;
   logic             len_adv;
   logic             crc_init;
   logic             crc_en;
   logic [31:0]      crc;

   eth_tgen_fsm #(
      .CNT_W (CNT_W),
      .LEN_W (LEN_W),
      .GAP_W (GAP_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cfg_count   (cfg_count),
      .cfg_gap     (cfg_gap),
      .cfg_pad_en  (cfg_pad_en),
      .cfg_vlan_en (cfg_vlan_en),
      .pause_en    (pause_en),
      .pause       (pause),
      .cur_len     (cur_len),
      .state_o     (state),
      .idx_o       (idx),
      .vlan_o      (vlan),
      .busy_o      (busy),
      .len_load_o  (len_load),
      .len_adv_o   (len_adv),
      .crc_init_o  (crc_init)
   );

   eth_tgen_lenseq #(
      .LEN_W (LEN_W)
   ) u_len (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (len_load),
      .adv   (len_adv),
      .first (cfg_len_first),
      .step  (cfg_len_step),
      .lmax  (cfg_len_max),
      .len   (cur_len)
   );

   eth_tgen_bytemux #(
      .LEN_W    (LEN_W),
      .DST_ADDR (DST_ADDR),
      .SRC_ADDR (SRC_ADDR),
      .TAG_CTRL (TAG_CTRL)
   ) u_mux (
      .state  (state),
      .idx    (idx),
      .len    (cur_len),
      .vlan   (vlan),
      .crc    (crc),
      .data   (tx_data),
      .valid  (tx_valid),
      .crc_en (crc_en)
   );

   eth_tgen_crc u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .en    (crc_en),
      .din   (tx_data),
      .crc   (crc)
   );

endmodule

// File: rtl/eth_tgen_chk.sv
module eth_tgen_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] cfg_count,
   input logic             pause_en,
   input logic             pause,
   input logic [7:0]       tx_data,
   input logic             tx_valid,
   input logic             busy
);

   // R2
   valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && cfg_count != '0) |=> busy);

   // R2
   run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tx_valid));

   // R3
   frame_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> tx_data == 8'h55);

   // R10
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_en && pause && !tx_valid) |=> !tx_valid);

endmodule

bind eth_tgen eth_tgen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .cfg_count (cfg_count),
   .pause_en  (pause_en),
   .pause     (pause),
   .tx_data   (tx_data),
   .tx_valid  (tx_valid),
   .busy      (busy)
);

// File: tb/eth_tgen_bench.sv
module eth_tgen_bench;

   localparam int CNT_W = 16;
   localparam int LEN_W = 11;
   localparam int GAP_W = 8;

   typedef struct packed {
      logic [CNT_W-1:0] count;
      logic [LEN_W-1:0] first;
      logic [LEN_W-1:0] step;
      logic [LEN_W-1:0] lmax;
      logic [GAP_W-1:0] gap;
      logic             pad;
      logic             vlan;
      logic [LEN_W-1:0] last_len;
   } vec_t;

   localparam int NVEC = 5;
   localparam vec_t VEC [0:NVEC-1] = '{
      '{16'd5, 11'd100,  11'd1,  11'd1500, 8'd12, 1'b1, 1'b0, 11'd104},
      '{16'd4, 11'd10,   11'd20, 11'd45,   8'd3,  1'b1, 1'b0, 11'd20},
      '{16'd3, 11'd0,    11'd5,  11'd100,  8'd1,  1'b0, 1'b0, 11'd10},
      '{16'd3, 11'd40,   11'd7,  11'd50,   8'd0,  1'b1, 1'b1, 11'd0},
      '{16'd2, 11'd1500, 11'd1,  11'd1500, 8'd5,  1'b0, 1'b1, 11'd0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic [LEN_W-1:0] cfg_len_first = '0;
   logic [LEN_W-1:0] cfg_len_step = '0;
   logic [LEN_W-1:0] cfg_len_max = '0;
   logic [GAP_W-1:0] cfg_gap = '0;
   logic             cfg_pad_en = 1'b0;
   logic             cfg_vlan_en = 1'b0;
   logic             pause_en = 1'b0;
   logic             pause = 1'b0;
   logic [7:0]       tx_data;
   logic             tx_valid;
   logic             busy;

   always #10 clk = ~clk;

   eth_tgen u_eth_tgen (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .cfg_count     (cfg_count),
      .cfg_len_first (cfg_len_first),
      .cfg_len_step  (cfg_len_step),
      .cfg_len_max   (cfg_len_max),
      .cfg_gap       (cfg_gap),
      .cfg_pad_en    (cfg_pad_en),
      .cfg_vlan_en   (cfg_vlan_en),
      .pause_en      (pause_en),
      .pause         (pause),
      .tx_data       (tx_data),
      .tx_valid      (tx_valid),
      .busy          (busy)
   );

   int checks = 0;
   int failures = 0;

   // model state of the current run
   int m_len, m_step, m_max, m_gap;
   bit m_pad, m_vlan, chk_gap;
   int run_frames = 0;
   int last_type = 0;

   logic [7:0] cap  [0:2047];
   logic [7:0] expf [0:2047];
   int cap_n = 0, exp_n = 0, idle = 0;
   bit in_frame = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      for (int b = 0; b < 8; b++)
         c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      return c;
   endfunction

   task automatic build_expected();
      logic [47:0] da = 48'h02_11_22_33_44_55;
      logic [47:0] sa = 48'h02_66_77_88_99_AA;
      logic [31:0] c = 32'hFFFF_FFFF;
      int n = 0;
      int body;
      for (int i = 0; i < 7; i++) begin expf[n] = 8'h55; n++; end
      expf[n] = 8'hD5; n++;
      for (int i = 0; i < 6; i++) begin expf[n] = da[47-8*i -: 8]; n++; end
      for (int i = 0; i < 6; i++) begin expf[n] = sa[47-8*i -: 8]; n++; end
      if (m_vlan) begin
         expf[n] = 8'h81; expf[n+1] = 8'h00; expf[n+2] = 8'h20; expf[n+3] = 8'h64; n += 4;
      end
      expf[n] = 8'(m_len >> 8); expf[n+1] = 8'(m_len); n += 2;
      for (int i = 0; i < m_len; i++) begin expf[n] = 8'(i); n++; end
      while (m_pad && (n - 8) < 60) begin expf[n] = 8'h00; n++; end
      body = n;
      for (int i = 8; i < body; i++) c = crc_step(c, expf[i]);
      c = ~c;
      for (int i = 0; i < 4; i++) begin expf[n] = c[8*i +: 8]; n++; end
      exp_n = n;
   endtask

   task automatic check_frame();
      int hlen = m_vlan ? 18 : 14;
      int tpos = 8 + hlen - 2;
      int typ;
      bit hdr_ok = 1, pay_ok = 1, fcs_ok = 1;
      build_expected();
      typ = {24'h0, cap[tpos]} * 256 + {24'h0, cap[tpos+1]};
      last_type = typ;
      check(typ == m_len, "R4 type/length field", typ, m_len);
      check(cap_n == exp_n, m_pad ? "R5 padded frame size" : "R6 unpadded frame size",
            cap_n, exp_n);
      if (cap_n == exp_n) begin
         for (int i = 0; i < 8 + hlen; i++) if (cap[i] !== expf[i]) hdr_ok = 0;
         for (int i = 8 + hlen; i < exp_n - 4; i++) if (cap[i] !== expf[i]) pay_ok = 0;
         for (int i = exp_n - 4; i < exp_n; i++) if (cap[i] !== expf[i]) fcs_ok = 0;
      end else begin
         hdr_ok = 0; pay_ok = 0; fcs_ok = 0;
      end
      check(hdr_ok, m_vlan ? "R7 tagged header" : "R3 header", hdr_ok, 1);
      check(pay_ok, "R3 payload and padding bytes", pay_ok, 1);
      check(fcs_ok, "R8 frame check sequence", fcs_ok, 1);
      if (m_len + m_step > m_max) m_len = 0;
      else m_len = m_len + m_step;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid) begin
            if (!in_frame) begin
               in_frame = 1;
               cap_n = 0;
               if (chk_gap && run_frames > 0)
                  check(idle == ((m_gap == 0) ? 1 : m_gap), "R9 inter-frame gap",
                        idle, (m_gap == 0) ? 1 : m_gap);
            end
            cap[cap_n] = tx_data;
            cap_n++;
            idle = 0;
         end else begin
            if (in_frame) begin
               in_frame = 0;
               check_frame();
               run_frames++;
            end
            idle++;
         end
      end
   end

   task automatic apply_cfg(input int cnt, input int first, input int step, input int lmax,
                            input int gap, input bit pad, input bit vlan);
      @(negedge clk);
      cfg_count     = CNT_W'(cnt);
      cfg_len_first = LEN_W'(first);
      cfg_len_step  = LEN_W'(step);
      cfg_len_max   = LEN_W'(lmax);
      cfg_gap       = GAP_W'(gap);
      cfg_pad_en    = pad;
      cfg_vlan_en   = vlan;
      m_len = first; m_step = step; m_max = lmax; m_gap = gap;
      m_pad = pad; m_vlan = vlan;
      run_frames = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0 && busy == 1'b0, "R1 outputs in reset", {tx_valid, busy}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0 && busy == 1'b0, "R1 outputs after reset", {tx_valid, busy}, 0);

      // vector table: R2 R4 R5 R6 R7 R8 R9
      chk_gap = 1;
      for (int v = 0; v < NVEC; v++) begin
         apply_cfg(int'(VEC[v].count), int'(VEC[v].first), int'(VEC[v].step),
                   int'(VEC[v].lmax), int'(VEC[v].gap), VEC[v].pad, VEC[v].vlan);
         pulse_start();
         check(busy == 1'b1, "R2 busy after start", busy, 1);
         wait_idle();
         check(run_frames == int'(VEC[v].count), "R2 frames per run", run_frames,
               int'(VEC[v].count));
         check(last_type == int'(VEC[v].last_len), "R4 last payload length", last_type,
               int'(VEC[v].last_len));
      end

      // R2: zero count launches nothing
      apply_cfg(0, 20, 1, 100, 4, 1, 0);
      pulse_start();
      repeat (20) @(negedge clk);
      check(busy == 1'b0 && run_frames == 0, "R2 zero count run", run_frames, 0);

      // R2 and R11: start and configuration changes during a run are ignored
      apply_cfg(3, 30, 2, 200, 6, 1, 0);
      pulse_start();
      repeat (30) @(negedge clk);
      cfg_count = 16'd9; cfg_len_first = 11'd5; cfg_len_step = 11'd50;
      cfg_vlan_en = 1'b1; cfg_pad_en = 1'b0; cfg_gap = 8'd1;
      pulse_start();
      wait_idle();
      check(run_frames == 3, "R11 run keeps its snapshot", run_frames, 3);

      // R10: pause mid-frame lets the frame finish, then holds
      chk_gap = 0;
      pause_en = 1'b1;
      apply_cfg(3, 20, 0, 100, 4, 1, 0);
      pulse_start();
      while (!tx_valid) @(negedge clk);
      repeat (5) @(negedge clk);
      pause = 1'b1;
      repeat (100) @(negedge clk);
      check(run_frames == 1, "R10 frame in progress completes", run_frames, 1);
      repeat (100) @(negedge clk);
      check(run_frames == 1 && tx_valid == 1'b0 && busy == 1'b1, "R10 held while paused",
            run_frames, 1);
      pause = 1'b0;
      wait_idle();
      check(run_frames == 3, "R10 resumes after release", run_frames, 3);

      // R10: pause has no effect when not enabled
      pause_en = 1'b0;
      pause = 1'b1;
      apply_cfg(2, 8, 3, 100, 2, 0, 1);
      pulse_start();
      wait_idle();
      check(run_frames == 2, "R10 pause ignored when disabled", run_frames, 2);
      pause = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule